// File: doc/BRIEF.md
# Miscellaneous System Control Registers

This block gathers a set of small control registers that a workstation-class system keeps outside its main peripherals. It has a configuration byte, a diagnostic byte, a modem-control byte, a 16-bit indicator-lamp word, a system-control word and two auxiliary bytes. Each register sits in its own address region, and that region is picked by its own select line. An access also carries a size code, an offset within the region and write data. Read data comes back combinationally in the same cycle as the read strobe.

Two registers do more than hold a value. The first auxiliary byte turns a written strobe bit into a one-cycle terminal-count pulse for a floppy controller. The second auxiliary byte (the power register) holds a sticky power-fail status, driven by an asynchronous power-fail input after a two-flop synchronizer. It also accepts a software power-off bit, which raises a shutdown request. A write to the system-control word can raise a reset request. The interrupt output reports a pending power failure while the configuration enable is set.

Top module: `sysmisc_regs`

## Requirements
- R1: `irq` is high exactly when power register bit 5 and configuration bit 3 are both set. It follows a configuration write in the very next cycle.
- R2: `pfail_in` passes through a two-flop synchronizer. When the synchronized level changes, power register bit 5 is set if the new level is high and configuration bit 3 is set, and cleared otherwise. A level that stays steady never changes bit 5.
- R3: A valid write to the power register keeps only data bits 0 and 1, and bit 5 keeps its current value. All other written bits read back as 0.
- R4: If a power register write has data bit 1 set, the stored value becomes data bit 0 alone. This clears bit 5 and drops `irq`. Bit 1 always reads back as 0.
- R5: When the value stored by a power register write has bit 0 set, `shutdown_req` is high for exactly the one cycle after that write.
- R6: A write to the first auxiliary byte with data bit 1 set makes `tc_pulse` high for exactly the one cycle after the write. The byte stores the other data bits, and bit 1 reads back as 0.
- R7: A word write to the system-control register with data bit 0 set loads the value 0x02 and makes `reset_req` high for one cycle. A write with bit 0 clear changes nothing and gives no pulse.
- R8: An access to the system-control region at a nonzero offset, or with a size other than word, reads 0 and is ignored on write.
- R9: `sel` bit 0 selects configuration, bit 1 diagnostic, bit 2 modem control, bit 3 lamps, bit 4 system control, bit 5 the first auxiliary byte and bit 6 the power register. `acc_size` is 0 for byte, 1 for half-word and 2 for word. The lamp word accepts only half-word accesses and the byte registers accept only byte accesses, all at offset 0. Any other access reads 0 and is ignored on write.
- R10: Reset clears configuration, modem control and both auxiliary bytes to 0. The diagnostic byte, lamp word and system-control value keep their contents across reset.
- R11: The diagnostic and modem-control bytes store and return all eight written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 7 | One select per register region (see R9) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| acc_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| acc_off | input | 2 | Byte offset inside the selected region |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Read data, same cycle as the read strobe |
| pfail_in | input | 1 | Asynchronous power-fail indication |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Terminal-count strobe to the floppy controller |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach from the ports is software clearing the sticky power-fail status while the synchronized input stays high. The status must then stay clear, because only a level change may set it again. A second hard case is a pending status held while the enable is toggled off and on. The stimulus keeps `pfail_in` asserted across a clear write and across configuration rewrites. It also raises the input once with the enable off, to show the gating. It then checks `irq` and the power register readback several cycles later, once the synchronizer has settled.

// File: rtl/sysmisc_pkg.sv
package sysmisc_pkg;

    localparam int NREG    = 7;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;

    // Region indices, which are also the select bit positions.
    localparam int RG_CFG  = 0;
    localparam int RG_DIAG = 1;
    localparam int RG_MDM  = 2;
    localparam int RG_LED  = 3;
    localparam int RG_SYSC = 4;
    localparam int RG_AUX1 = 5;
    localparam int RG_AUX2 = 6;

    // Access size codes.
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Bit positions that other logic decodes.
    localparam int CFG_PFEN_B  = 3;
    localparam int AUX1_TC_B   = 1;
    localparam int AUX2_OFF_B  = 0;
    localparam int AUX2_CLR_B  = 1;
    localparam int AUX2_STAT_B = 5;
    localparam int SYSC_GO_B   = 0;
    localparam logic [BYTE_W-1:0] SYSC_DONE_VAL = 8'h02;

    // Size a region accepts; every region answers only at offset 0.
    function automatic logic [1:0] region_size(input int idx);
        case (idx)
            RG_LED:  return SZ_HALF;
            RG_SYSC: return SZ_WORD;
            default: return SZ_BYTE;
        endcase
    endfunction

    // Registers cleared by reset.
    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] mctrl;
        logic [BYTE_W-1:0] aux1;
        logic [BYTE_W-1:0] aux2;
    } ctl_t;

    // Registers that keep their value across reset.
    typedef struct packed {
        logic [BYTE_W-1:0] diag;
        logic [HALF_W-1:0] led;
        logic [BYTE_W-1:0] sysc;
    } keep_t;

    // Registered one-cycle strobes.
    typedef struct packed {
        logic tc;
        logic shdn;
        logic rst;
    } pulse_t;

endpackage

// File: rtl/sysmisc_sync.sv
module sysmisc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic chg
);
    // chain_q[STAGES-1] is the synchronized level; chain_q[STAGES] is its previous value.
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign lvl = chain_q[STAGES-1];
    assign chg = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/sysmisc_bus_dec.sv
module sysmisc_bus_dec
    import sysmisc_pkg::*;
(
    input  logic [NREG-1:0] sel,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      acc_size,
    input  logic [1:0]      acc_off,
    output logic [NREG-1:0] wr_hit,
    output logic [NREG-1:0] rd_hit
);
    for (genvar g = 0; g < NREG; g++) begin : g_region
        logic fit;
        assign fit       = sel[g] && (acc_size == region_size(g)) && (acc_off == 2'd0);
        assign wr_hit[g] = fit && wr_en;
        assign rd_hit[g] = fit && rd_en;
    end
endmodule

// File: rtl/sysmisc_regs.sv
module sysmisc_regs
    import sysmisc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pfail_in,
    output logic              irq,
    output logic              tc_pulse,
    output logic              shutdown_req,
    output logic              reset_req
);
    localparam logic [BYTE_W-1:0] AUX2_WR_MASK =
        BYTE_W'((1 << AUX2_OFF_B) | (1 << AUX2_CLR_B));
    localparam logic [BYTE_W-1:0] AUX2_STAT_MASK = BYTE_W'(1 << AUX2_STAT_B);
    localparam logic [BYTE_W-1:0] AUX2_OFF_MASK  = BYTE_W'(1 << AUX2_OFF_B);
    localparam logic [BYTE_W-1:0] AUX1_TC_MASK   = BYTE_W'(1 << AUX1_TC_B);

    logic [NREG-1:0] wr_hit, rd_hit;
    logic            pf_lvl, pf_chg;

    ctl_t   ctl_d,  ctl_q;
    keep_t  keep_d, keep_q;
    pulse_t pul_d,  pul_q;

    sysmisc_bus_dec u_dec (
        .sel      (sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .acc_size (acc_size),
        .acc_off  (acc_off),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    sysmisc_sync #(.STAGES(SYNC_STAGES)) u_pf_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pfail_in),
        .lvl   (pf_lvl),
        .chg   (pf_chg)
    );

    // Next-state logic
    always_comb begin
        logic [BYTE_W-1:0] aux2_new;
        ctl_d    = ctl_q;
        keep_d   = keep_q;
        pul_d    = '0;
        aux2_new = '0;

        if (wr_hit[RG_CFG])  ctl_d.cfg   = wdata[BYTE_W-1:0];
        if (wr_hit[RG_MDM])  ctl_d.mctrl = wdata[BYTE_W-1:0];
        if (wr_hit[RG_DIAG]) keep_d.diag = wdata[BYTE_W-1:0];
        if (wr_hit[RG_LED])  keep_d.led  = wdata[HALF_W-1:0];

        if (wr_hit[RG_AUX1]) begin
            ctl_d.aux1 = wdata[BYTE_W-1:0] & ~AUX1_TC_MASK;
            pul_d.tc   = wdata[AUX1_TC_B];
        end

        if (wr_hit[RG_AUX2]) begin
            aux2_new = (wdata[BYTE_W-1:0] & AUX2_WR_MASK) | (ctl_q.aux2 & AUX2_STAT_MASK);
            if (aux2_new[AUX2_CLR_B]) aux2_new = aux2_new & AUX2_OFF_MASK;
            ctl_d.aux2 = aux2_new;
            pul_d.shdn = aux2_new[AUX2_OFF_B];
        end

        if (wr_hit[RG_SYSC] && wdata[SYSC_GO_B]) begin
            keep_d.sysc = SYSC_DONE_VAL;
            pul_d.rst   = 1'b1;
        end

        // A level change of the synchronized input overrides the status bit.
        if (pf_chg) ctl_d.aux2[AUX2_STAT_B] = pf_lvl && ctl_q.cfg[CFG_PFEN_B];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            pul_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            pul_q <= pul_d;
        end
    end

    always_ff @(posedge clk) begin
        keep_q <= keep_d;
    end

    // Read return
    always_comb begin
        rdata = '0;
        if (rd_hit[RG_CFG])  rdata = DATA_W'(ctl_q.cfg);
        if (rd_hit[RG_DIAG]) rdata = DATA_W'(keep_q.diag);
        if (rd_hit[RG_MDM])  rdata = DATA_W'(ctl_q.mctrl);
        if (rd_hit[RG_LED])  rdata = DATA_W'(keep_q.led);
        if (rd_hit[RG_SYSC]) rdata = DATA_W'(keep_q.sysc);
        if (rd_hit[RG_AUX1]) rdata = DATA_W'(ctl_q.aux1);
        if (rd_hit[RG_AUX2]) rdata = DATA_W'(ctl_q.aux2);
    end

    assign irq          = ctl_q.aux2[AUX2_STAT_B] && ctl_q.cfg[CFG_PFEN_B];
    assign tc_pulse     = pul_q.tc;
    assign shutdown_req = pul_q.shdn;
    assign reset_req    = pul_q.rst;
endmodule

// File: rtl/sysmisc_chk.sv
module sysmisc_chk
    import sysmisc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREG-1:0]   sel,
    input logic              wr_en,
    input logic [1:0]        acc_size,
    input logic [1:0]        acc_off,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              tc_pulse,
    input logic              shutdown_req,
    input logic              reset_req,
    input logic              pf_lvl,
    input logic              pf_chg
);
    logic byte_ok, word_ok;
    assign byte_ok = wr_en && acc_size == SZ_BYTE && acc_off == 2'd0;
    assign word_ok = wr_en && acc_size == SZ_WORD && acc_off == 2'd0;

    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    a_r6_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(byte_ok && sel[RG_AUX1] && wdata[AUX1_TC_B]));

    a_r5_shdn_cause: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(byte_ok && sel[RG_AUX2] && wdata[AUX2_OFF_B]));

    a_r7_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(word_ok && sel[RG_SYSC] && wdata[SYSC_GO_B]));

    a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !(word_ok && sel[RG_SYSC])) |=> !reset_req);

    a_r4_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && sel[RG_AUX2] && wdata[AUX2_CLR_B] && !pf_chg) |=> !irq);

    a_r2_low_input_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !pf_lvl) |=> !irq);
endmodule

bind sysmisc_regs sysmisc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (sel),
    .wr_en        (wr_en),
    .acc_size     (acc_size),
    .acc_off      (acc_off),
    .wdata        (wdata),
    .irq          (irq),
    .tc_pulse     (tc_pulse),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .pf_lvl       (pf_lvl),
    .pf_chg       (pf_chg)
);

// File: tb/sysmisc_regs_tb_top.sv
`timescale 1ns/1ps
module sysmisc_regs_tb_top;
    localparam int K_RD = 0, K_IRQ = 1, K_TC = 2, K_SHDN = 3, K_RST = 4;
    localparam int CFG = 0, DIAG = 1, MDM = 2, LED = 3, SYSC = 4, AUX1 = 5, AUX2 = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  sel = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  acc_size = '0, acc_off = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pfail = 1'b0;
    logic        irq, tc_pulse, shutdown_req, reset_req;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    int          kq[$];
    logic [31:0] eq[$];
    string       rq[$];

    always #2.5 clk = ~clk;

    sysmisc_regs dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .acc_size(acc_size), .acc_off(acc_off), .wdata(wdata), .rdata(rdata),
        .pfail_in(pfail), .irq(irq), .tc_pulse(tc_pulse),
        .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    // Monitor: compares queued expectations in the middle of the cycle.
    always @(negedge clk) begin
        while (kq.size() > 0) begin
            int          k;
            logic [31:0] e, a;
            string       r;
            k = kq.pop_front();
            e = eq.pop_front();
            r = rq.pop_front();
            case (k)
                K_RD:    a = rdata;
                K_IRQ:   a = {31'd0, irq};
                K_TC:    a = {31'd0, tc_pulse};
                K_SHDN:  a = {31'd0, shutdown_req};
                default: a = {31'd0, reset_req};
            endcase
            n_tests++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=0x%08h expected=0x%08h", r, k, a, e);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int k, logic [31:0] e, string r);
        kq.push_back(k);
        eq.push_back(e);
        rq.push_back(r);
    endtask

    task automatic wr(int r, int sz, int o, logic [31:0] d);
        sel = 7'(1 << r); wr_en = 1'b1; acc_size = 2'(sz); acc_off = 2'(o); wdata = d;
        cyc();
        sel = '0; wr_en = 1'b0; wdata = '0; acc_size = '0; acc_off = '0;
    endtask

    task automatic rd(int r, int sz, int o, logic [31:0] e, string req);
        sel = 7'(1 << r); rd_en = 1'b1; acc_size = 2'(sz); acc_off = 2'(o);
        push(K_RD, e, req);
        cyc();
        sel = '0; rd_en = 1'b0; acc_size = '0; acc_off = '0;
    endtask

    task automatic settle();
        repeat (5) cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R10: reset state
        push(K_IRQ, 0, "R10 irq after reset");
        rd(CFG, 0, 0, 32'h0, "R10 cfg reset");
        rd(AUX1, 0, 0, 32'h0, "R10 aux1 reset");
        rd(AUX2, 0, 0, 32'h0, "R10 aux2 reset");
        rd(MDM, 0, 0, 32'h0, "R10 mctrl reset");

        // R11: plain storage
        wr(DIAG, 0, 0, 32'hFFFF_FFA5);
        rd(DIAG, 0, 0, 32'hA5, "R11 diag");
        wr(MDM, 0, 0, 32'h3C);
        rd(MDM, 0, 0, 32'h3C, "R11 mctrl");

        // R6: terminal count strobe
        wr(CFG, 0, 0, 32'h08);
        rd(CFG, 0, 0, 32'h08, "R1 cfg readback");
        wr(AUX1, 0, 0, 32'h83);
        push(K_TC, 1, "R6 tc pulse");
        rd(AUX1, 0, 0, 32'h81, "R6 aux1 strobe bit dropped");
        push(K_TC, 0, "R6 tc single cycle");
        cyc();
        wr(AUX1, 0, 0, 32'h40);
        push(K_TC, 0, "R6 no tc without bit1");
        rd(AUX1, 0, 0, 32'h40, "R6 aux1 store");

        // R2, R1: power fail sets status
        pfail = 1'b1;
        settle();
        push(K_IRQ, 1, "R1 irq on power fail");
        rd(AUX2, 0, 0, 32'h20, "R2 status set");

        // R3: carry and masking
        wr(AUX2, 0, 0, 32'h00);
        rd(AUX2, 0, 0, 32'h20, "R3 status carried");
        wr(AUX2, 0, 0, 32'hFC);
        rd(AUX2, 0, 0, 32'h20, "R3 upper bits masked");

        // R4: clear while input stays high
        wr(AUX2, 0, 0, 32'h02);
        push(K_IRQ, 0, "R4 irq dropped");
        rd(AUX2, 0, 0, 32'h00, "R4 status cleared");
        settle();
        push(K_IRQ, 0, "R2 held input does not re-set");
        rd(AUX2, 0, 0, 32'h00, "R2 no re-set while steady");

        // R2: gating by enable
        pfail = 1'b0;
        settle();
        wr(CFG, 0, 0, 32'h00);
        pfail = 1'b1;
        settle();
        rd(AUX2, 0, 0, 32'h00, "R2 gated by enable");
        pfail = 1'b0;
        settle();
        wr(CFG, 0, 0, 32'h08);
        pfail = 1'b1;
        settle();
        push(K_IRQ, 1, "R1 irq with enable");
        rd(AUX2, 0, 0, 32'h20, "R2 set with enable");

        // R1: enable masks irq, status kept
        wr(CFG, 0, 0, 32'h00);
        push(K_IRQ, 0, "R1 irq masked by cfg");
        rd(AUX2, 0, 0, 32'h20, "R1 status kept while masked");
        wr(CFG, 0, 0, 32'h08);
        push(K_IRQ, 1, "R1 irq back on");
        cyc();

        // R5: shutdown
        wr(AUX2, 0, 0, 32'h01);
        push(K_SHDN, 1, "R5 shutdown pulse");
        rd(AUX2, 0, 0, 32'h21, "R5 off bit stored");
        push(K_SHDN, 0, "R5 shutdown single cycle");
        push(K_IRQ, 1, "R1 irq kept");
        cyc();
        wr(AUX2, 0, 0, 32'h03);
        push(K_SHDN, 1, "R5 shutdown with clear");
        push(K_IRQ, 0, "R4 clear with off");
        rd(AUX2, 0, 0, 32'h01, "R4 only off bit kept");
        wr(AUX2, 0, 0, 32'h00);
        push(K_SHDN, 0, "R5 no shutdown");
        rd(AUX2, 0, 0, 32'h00, "R3 off bit cleared");
        pfail = 1'b0;
        settle();

        // R7, R8: system control
        wr(SYSC, 2, 0, 32'h1);
        push(K_RST, 1, "R7 reset pulse");
        rd(SYSC, 2, 0, 32'h02, "R7 reset status");
        push(K_RST, 0, "R7 reset single cycle");
        cyc();
        wr(SYSC, 2, 0, 32'h0);
        push(K_RST, 0, "R7 no pulse without bit0");
        rd(SYSC, 2, 0, 32'h02, "R7 value unchanged");
        rd(SYSC, 2, 1, 32'h0, "R8 offset read zero");
        rd(SYSC, 0, 0, 32'h0, "R8 byte read zero");
        wr(SYSC, 0, 0, 32'h1);
        push(K_RST, 0, "R8 byte write ignored");
        cyc();
        wr(SYSC, 2, 2, 32'h1);
        push(K_RST, 0, "R8 offset write ignored");
        cyc();

        // R9: lamp word and size checks
        wr(LED, 1, 0, 32'h1234_BEEF);
        rd(LED, 1, 0, 32'hBEEF, "R9 led half");
        wr(LED, 0, 0, 32'h12);
        rd(LED, 1, 0, 32'hBEEF, "R9 led byte write ignored");
        rd(LED, 0, 0, 32'h0, "R9 led byte read zero");
        wr(MDM, 1, 0, 32'h77);
        rd(MDM, 0, 0, 32'h3C, "R9 half write to byte reg ignored");
        wr(MDM, 0, 1, 32'h77);
        rd(MDM, 0, 0, 32'h3C, "R9 offset write ignored");
        rd(MDM, 1, 0, 32'h0, "R9 half read of byte reg zero");

        // R10: reset keeps diag, lamps, system control
        wr(CFG, 0, 0, 32'h08);
        wr(AUX1, 0, 0, 32'h81);
        wr(DIAG, 0, 0, 32'h5A);
        rst_n = 1'b0;
        cyc();
        cyc();
        rst_n = 1'b1;
        cyc();
        rd(CFG, 0, 0, 32'h0, "R10 cfg cleared");
        rd(AUX1, 0, 0, 32'h0, "R10 aux1 cleared");
        rd(MDM, 0, 0, 32'h0, "R10 mctrl cleared");
        rd(DIAG, 0, 0, 32'h5A, "R10 diag kept");
        rd(LED, 1, 0, 32'hBEEF, "R10 led kept");
        rd(SYSC, 2, 0, 32'h02, "R10 sysc kept");
        cyc();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule